// File: doc/BRIEF.md
# Message-Signalled Interrupt Address Composer

This block turns one interrupt routing word into a single memory write for a message-signalled interrupt. The routing word names a destination hart, a guest interrupt file and an interrupt identity. The block places these fields into a 64-bit byte address. The placement follows a pair of configuration words. The high configuration word holds the field widths, the field shifts, the upper base page bits and a sticky lock bit. The 32-bit data of the write is the interrupt identity.

Software programs the two configuration words through a simple write/read port, selecting the low word with `cfg_sel` = 0 and the high word with `cfg_sel` = 1. A source presents a routing word with `req_valid`. The composer captures it in one registered stage and holds the resulting address/data pair on a valid/ready output until the bus side takes it. The parameter `MACHINE_LEVEL` selects a machine-level domain, in which the guest field of the routing word is not used.

Top module: `msi_addr_composer`

## Requirements
- R1: After reset `msg_valid` is 0, `req_ready` is 1, and both configuration words read back as 0.
- R2: The low word stores all 32 written bits. The high word stores only these fields and reads 0 in every other bit: lock at bit 31, group shift HS at 28:24, hart shift LS at 22:20, group width GW at 18:16, hart width LW at 15:12, and base page bits at 11:0. The storage mask is 0x9F77FFFF.
- R3: While bit 31 of the stored high word is 1, writes to either configuration word leave both words unchanged. Only a reset clears the lock.
- R4: The routing word is split as follows: hart index H at 31:18, guest index G at 17:12, identity at 10:0. The group is H shifted right by LW, masked to GW bits. The local index is H masked to LW bits.
- R5: `msg_addr` equals P shifted left by 12, truncated to 64 bits. P is the OR of four terms: {base bits, low word} with the base bits at bit 32 upward, the group shifted left by HS+12, the local index shifted left by LS, and G masked to LS bits.
- R6: With `MACHINE_LEVEL` = 1, the guest index is taken as 0 whatever the routing word carries.
- R7: `msg_data` equals the 11-bit identity of the routing word, zero-extended to 32 bits.
- R8: `req_ready` is 1 exactly when no message is held. A request accepted at a clock edge makes `msg_valid` 1 from that edge on. If a message is taken and no request is accepted at the same edge, `msg_valid` drops to 0.
- R9: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid`, `msg_addr` and `msg_data` stay unchanged, and new requests are not accepted.
- R10: When a configuration write and a request acceptance happen at the same edge, the message is composed from the configuration as it stood before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Selects the configuration word: 0 is the low word, 1 is the high word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data of the selected configuration word |
| req_valid | input | 1 | A routing word is offered |
| req_ready | output | 1 | The composer can take a routing word |
| req_route | input | 32 | Routing word: hart, guest, identity |
| msg_valid | output | 1 | The address/data pair is valid |
| msg_ready | input | 1 | The bus side takes the pair |
| msg_addr | output | 64 | Byte address of the message write |
| msg_data | output | 32 | Data of the message write |

## Verification
A configuration write and a request acceptance can fall in the same edge. The bench provokes this by raising `cfg_we` on the high word together with `req_valid` while the output is empty. It then checks that the emitted address matches the expectation built from the old high word, and that a read afterwards returns the newly written, masked value. A second overlap is a taken message and a held request. This case is judged by checking that no request is captured until the output is empty, and that the message that finally appears belongs to the later routing word.

// File: rtl/msi_addr_composer.sv
module msi_addr_composer #(
  parameter bit MACHINE_LEVEL = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_route,
  output logic        msg_valid,
  input  logic        msg_ready,
  output logic [63:0] msg_addr,
  output logic [31:0] msg_data
);
  localparam logic [31:0] HI_KEEP = 32'h9F77_FFFF;
  localparam int          PAGE_SH = 12;

  logic [31:0] lo_q, hi_q;
  logic        locked;

  assign locked    = hi_q[31];
  assign cfg_rdata = cfg_sel ? hi_q : lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (cfg_we && !locked) begin
      if (cfg_sel) hi_q <= cfg_wdata & HI_KEEP;
      else         lo_q <= cfg_wdata;
    end
  end

  // R3
  property lock_freeze_p;
    @(posedge clk) disable iff (!rst_n)
      locked |=> locked && $stable(lo_q) && $stable(hi_q);
  endproperty
  lock_freeze_chk: assert property (lock_freeze_p);

  logic [4:0]  grp_shift;
  logic [2:0]  hart_shift;
  logic [2:0]  grp_width;
  logic [3:0]  hart_width;
  logic [11:0] base_hi;

  assign grp_shift  = hi_q[28:24];
  assign hart_shift = hi_q[22:20];
  assign grp_width  = hi_q[18:16];
  assign hart_width = hi_q[15:12];
  assign base_hi    = hi_q[11:0];

  logic [13:0] hart_idx, grp_idx, grp_keep, loc_idx, loc_mask;
  logic [5:0]  guest_idx, guest_keep;
  logic [10:0] ident;

  assign hart_idx  = req_route[31:18];
  assign guest_idx = MACHINE_LEVEL ? 6'd0 : req_route[17:12];
  assign ident     = req_route[10:0];

  assign loc_mask   = 14'((15'd1 << hart_width) - 15'd1);
  assign grp_idx    = hart_idx >> hart_width;
  assign grp_keep   = grp_idx & {7'd0, 7'((8'd1 << grp_width) - 8'd1)};
  assign loc_idx    = hart_idx & loc_mask;
  assign guest_keep = guest_idx & 6'((8'd1 << hart_shift) - 8'd1);

  logic [63:0] page_num, addr_next;
  logic [5:0]  grp_pos;

  assign grp_pos   = {1'b0, grp_shift} + 6'd12;
  assign page_num  = {20'd0, base_hi, lo_q}
                   | (64'(grp_keep) << grp_pos)
                   | (64'(loc_idx) << hart_shift)
                   | 64'(guest_keep);
  assign addr_next = page_num << PAGE_SH;

  logic take;
  assign req_ready = !msg_valid;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (take) begin
      msg_valid <= 1'b1;
      msg_addr  <= addr_next;
      msg_data  <= {21'd0, ident};
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  // R8
  property accept_rise_p;
    @(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> msg_valid;
  endproperty
  accept_rise_chk: assert property (accept_rise_p);

  // R8
  property drain_fall_p;
    @(posedge clk) disable iff (!rst_n)
      msg_valid && msg_ready && !req_valid |=> !msg_valid;
  endproperty
  drain_fall_chk: assert property (drain_fall_p);

  // R9
  property hold_stable_p;
    @(posedge clk) disable iff (!rst_n)
      msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data);
  endproperty
  hold_stable_chk: assert property (hold_stable_p);
endmodule

// File: tb/sim_msi_addr_composer.sv
module sim_msi_addr_composer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_route = '0;
  logic        msg_ready = 1'b0;

  logic [31:0] rd0, rd1, data0, data1;
  logic        rdy0, rdy1, val0, val1;
  logic [63:0] addr0, addr1;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  msi_addr_composer #(.MACHINE_LEVEL(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd0), .req_valid(req_valid),
    .req_ready(rdy0), .req_route(req_route), .msg_valid(val0),
    .msg_ready(msg_ready), .msg_addr(addr0), .msg_data(data0));

  msi_addr_composer #(.MACHINE_LEVEL(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd1), .req_valid(req_valid),
    .req_ready(rdy1), .req_route(req_route), .msg_valid(val1),
    .msg_ready(msg_ready), .msg_addr(addr1), .msg_data(data1));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [31:0] lo, input logic [31:0] hi,
                                        input logic [31:0] route, input bit mach);
    longint unsigned lw, ls, gw, gs, hart, guest, grp, loc, pg;
    lw    = 64'(hi[15:12]);
    ls    = 64'(hi[22:20]);
    gw    = 64'(hi[18:16]);
    gs    = 64'(hi[28:24]);
    hart  = 64'(route[31:18]);
    guest = mach ? 0 : 64'(route[17:12]);
    grp   = (hart / (64'd1 << lw)) % (64'd1 << gw);
    loc   = hart % (64'd1 << lw);
    pg    = (64'(hi[11:0]) * 64'h1_0000_0000 + 64'(lo))
          | (grp << (gs + 12)) | (loc << ls) | (guest % (64'd1 << ls));
    return pg << 12;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_we = 1'b0; req_valid = 1'b0; msg_ready = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input bit sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input bit sel, output logic [31:0] v);
    cfg_sel = sel;
    #1;
    v = rd0;
  endtask

  task automatic send(input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] route, input string req);
    @(negedge clk);
    chk(val0 == 1'b0 && rdy0 == 1'b1, "R8", {62'd0, val0, rdy0}, 64'd1);
    req_valid = 1'b1; req_route = route;
    @(negedge clk);
    req_valid = 1'b0;
    chk(val0 == 1'b1 && rdy0 == 1'b0, "R8", {62'd0, val0, rdy0}, 64'd2);
    chk(addr0 == model(lo, hi, route, 1'b0), req, addr0, model(lo, hi, route, 1'b0));
    chk(addr1 == model(lo, hi, route, 1'b1), "R6", addr1, model(lo, hi, route, 1'b1));
    chk(data0 == {21'd0, route[10:0]}, "R7", 64'(data0), 64'(route[10:0]));
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
    chk(val0 == 1'b0, "R8", 64'(val0), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, lo, hi, route;
    int k;
    k = 0;
    do_reset();
    @(negedge clk);
    // R1
    chk(val0 == 1'b0 && rdy0 == 1'b1, "R1", {62'd0, val0, rdy0}, 64'd1);
    rd(1'b0, v); chk(v == 32'd0, "R1", 64'(v), 64'd0);
    rd(1'b1, v); chk(v == 32'd0, "R1", 64'(v), 64'd0);

    // R2
    wr(1'b1, 32'h7FFF_FFFF); rd(1'b1, v);
    chk(v == 32'h1F77_FFFF, "R2", 64'(v), 64'h1F77_FFFF);
    wr(1'b0, 32'hFFFF_FFFF); rd(1'b0, v);
    chk(v == 32'hFFFF_FFFF, "R2", 64'(v), 64'hFFFF_FFFF);

    // R4 R5 sweep over widths and shifts
    for (int lw = 0; lw < 16; lw += 3) begin
      for (int ls = 0; ls < 8; ls++) begin
        for (int gi = 0; gi < 3; gi++) begin
          for (int si = 0; si < 3; si++) begin
            int gw, gs;
            gw = (gi == 0) ? 0 : (gi == 1) ? 2 : 7;
            gs = (si == 0) ? 0 : (si == 1) ? 7 : 31;
            lo = 32'hA500_0000 ^ 32'(k * 977);
            hi = {1'b0, 2'b00, 5'(gs), 1'b0, 3'(ls), 1'b0, 3'(gw), 4'(lw), 12'(k * 37 + 1)};
            wr(1'b0, lo);
            wr(1'b1, hi);
            route = {14'(k * 1237 + lw * 91), 6'(k * 7 + ls), 1'b0, 11'(k * 173 + 5)};
            send(lo, hi, route, "R5");
            route = {14'h3FFF, 6'h3F, 1'b1, 11'h7FF};
            send(lo, hi, route, "R4");
            k++;
          end
        end
      end
    end

    // R10: config write and acceptance at the same edge
    lo = 32'h0001_2000; hi = 32'h0312_3005;
    wr(1'b0, lo); wr(1'b1, hi);
    route = {14'd45, 6'd9, 1'b0, 11'd300};
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 32'h0007_1FFF;
    req_valid = 1'b1; req_route = route;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk(addr0 == model(lo, hi, route, 1'b0), "R10", addr0, model(lo, hi, route, 1'b0));
    rd(1'b1, v); chk(v == 32'h0007_1FFF, "R10", 64'(v), 64'h0007_1FFF);
    hi = 32'h0007_1FFF;

    // R9: held output, second request blocked
    req_valid = 1'b1; req_route = {14'd3, 6'd1, 1'b0, 11'd77};
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(val0 == 1'b1 && rdy0 == 1'b0, "R9", {62'd0, val0, rdy0}, 64'd2);
      chk(addr0 == model(lo, 32'h0312_3005, route, 1'b0) && data0 == 32'd300, "R9",
          addr0, model(lo, 32'h0312_3005, route, 1'b0));
    end
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
    req_valid = 1'b0;
    chk(val0 == 1'b0 && rdy0 == 1'b1, "R9", {62'd0, val0, rdy0}, 64'd1);
    @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(val0 == 1'b1 && data0 == 32'd77, "R9", 64'(data0), 64'd77);
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;

    // R3: lock freezes both words
    wr(1'b0, 32'h0000_4440);
    wr(1'b1, 32'h8011_2003);
    wr(1'b0, 32'hDEAD_0000);
    wr(1'b1, 32'h0000_0000);
    rd(1'b0, v); chk(v == 32'h0000_4440, "R3", 64'(v), 64'h4440);
    rd(1'b1, v); chk(v == 32'h8011_2003, "R3", 64'(v), 64'h8011_2003);
    route = {14'd11, 6'd2, 1'b0, 11'd19};
    send(32'h0000_4440, 32'h8011_2003, route, "R3");

    // R1: reset clears the lock
    do_reset();
    @(negedge clk);
    rd(1'b1, v); chk(v == 32'd0, "R1", 64'(v), 64'd0);
    rd(1'b0, v); chk(v == 32'd0, "R1", 64'(v), 64'd0);
    wr(1'b0, 32'h1234_5678); rd(1'b0, v);
    chk(v == 32'h1234_5678, "R3", 64'(v), 64'h1234_5678);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule